// File: doc/BRIEF.md
# Receive Byte-Order Aligner

This block sits behind a receive deserializer that hands over two byte lanes per word (single-width) or four byte lanes per word (double-width). It looks through the word stream for a programmable ordering byte. When that byte shows up in a lane above lane 0, the block inserts programmable pad bytes so that the ordering byte moves down to lane 0. The bytes that the pads push out of the word are held over and emitted at the top of the next word. The output therefore stays a continuous byte stream, in the original order, with the ordering byte now on the word boundary.

The search can start in two ways. In automatic mode it starts as soon as the upstream word aligner reports sync. In user mode it starts on a rising edge of an enable input. When ordering finishes, a done flag rises and stays high. The shift amount chosen at that point stays fixed until a reset, a power-down, or a fresh user enable edge.

Top module: `bo_order_align`

## Requirements
- R1: When `rst` or `pwr_dn` is high at a clock edge, `out_valid` and `order_done` are low after that edge.
- R2: Until ordering completes, `out_data` equals the `in_data` of the previous cycle unchanged. In every state, `out_valid` equals the `in_valid` of the previous cycle. Words with `in_valid` low are neither searched nor stored as holdover.
- R3: In automatic mode (`mode_user`=0), a valid word is searched only while `sync_ok` is high. No ordering completes without a valid searched word that holds the ordering byte.
- R4: Lane i of a word is bits [8i+7:8i], and lane 0 is the least-significant byte. In stream order, a higher lane comes before a lower lane. When the ordering byte is found in lane k>0, the output word carries the ordering byte in lane 0, the pad byte in lanes 1..k, and input lanes above k unchanged. `order_done` is high together with that word.
- R5: After a lock at lane k, each output word carries lanes k-1..0 of the previous valid input in its top k lanes. Below them it carries lanes L-1..k of the current input, in order.
- R6: When the ordering byte is first found in lane 0, no pad byte is inserted, `order_done` rises, and data keeps passing through unshifted.
- R7: When the ordering byte appears in several lanes of one word, the lowest such lane sets the shift.
- R8: After completion the shift is frozen. Later ordering bytes in any lane do not change the alignment.
- R9: `order_done` stays high until `rst` or `pwr_dn` is asserted, or until a user-mode restart (R11).
- R10: In user mode (`mode_user`=1), a search begins one cycle after a rising edge of `ord_en`. The word presented in the edge cycle is not searched. `ord_en` held high does not restart anything, `sync_ok` is ignored, and a rising edge while a search is pending leaves the search pending.
- R11: In user mode, a rising edge of `ord_en` after completion clears `order_done` at the next edge. Words presented from the following cycle on pass with zero shift and are searched again; the pending holdover bytes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Synchronous power-down clear, same effect as reset |
| mode_user | input | 1 | 0: start on sync, 1: start on ord_en rising edge |
| ord_en | input | 1 | User start request, edge sensitive |
| sync_ok | input | 1 | Upstream word alignment achieved |
| order_byte | input | 8 | Ordering byte value to search for |
| pad_byte | input | 8 | Pad byte value inserted |
| in_valid | input | 1 | Input word valid |
| in_data | input | 8*LANES | Input word, lane 0 in the low byte |
| out_valid | output | 1 | Output word valid |
| out_data | output | 8*LANES | Reordered output word |
| order_done | output | 1 | Sticky ordering-complete status |

## Verification
The bench places the ordering byte at each offset, including lane 0 and the top lane, because a design that gets the pad count wrong puts the ordering byte in the wrong lane. It checks the word after a lock, since a bad holdover drops or repeats the displaced bytes. An invalid word sits between two shifted words; a design that latches holdover on invalid cycles would corrupt the next word. Other cases cover duplicate ordering bytes (a highest-lane pick gives the wrong shift), ordering bytes that appear after lock (an unfrozen shift would realign), an ordering byte present before sync or before the enable edge (an early search would lock too soon), and a restart after completion (a sticky shift would keep padding).

// File: rtl/bo_pkg.sv
package bo_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEEK   = 2'd1,
        ST_LOCKED = 2'd2
    } bo_state_e;
endpackage

// File: rtl/bo_find.sv
module bo_find
    import bo_pkg::*;
#(
    parameter int LANES = 4,
    localparam int W   = LANES * BYTE_W,
    localparam int SHW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [W-1:0]   in_data,
    input  byte_t          order_byte,
    output logic           hit_any,
    output logic [SHW-1:0] hit_lane
);
    logic [LANES-1:0] eq;

    for (genvar i = 0; i < LANES; i++) begin : g_cmp
        assign eq[i] = (in_data[i*BYTE_W +: BYTE_W] == order_byte);
    end

    // lowest matching lane wins: scan downward so the last write is the lowest
    always_comb begin
        hit_lane = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (eq[i]) hit_lane = SHW'(i);
        end
    end

    assign hit_any = |eq;
endmodule

// File: rtl/bo_ctl.sv
module bo_ctl
    import bo_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic mode_user,
    input  logic ord_en,
    input  logic sync_ok,
    input  logic in_valid,
    input  logic hit_any,
    output logic lock,
    output logic restart,
    output logic done
);
    bo_state_e st;
    logic      en_q;
    logic      rise;
    logic      active;

    assign rise    = mode_user & ord_en & ~en_q;
    assign active  = mode_user ? (st == ST_SEEK) : ((st != ST_LOCKED) & sync_ok);
    assign lock    = active & in_valid & hit_any;
    assign restart = rise & (st != ST_SEEK);
    assign done    = (st == ST_LOCKED);

    always_ff @(posedge clk) begin
        if (clr) begin
            st   <= ST_IDLE;
            en_q <= 1'b0;
        end else begin
            en_q <= ord_en;
            if (lock)
                st <= ST_LOCKED;
            else if (restart)
                st <= ST_SEEK;
        end
    end
endmodule

// File: rtl/bo_datapath.sv
module bo_datapath
    import bo_pkg::*;
#(
    parameter int LANES = 4,
    localparam int W   = LANES * BYTE_W,
    localparam int SHW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic           clk,
    input  logic           clr,
    input  logic           in_valid,
    input  logic [W-1:0]   in_data,
    input  logic           lock,
    input  logic [SHW-1:0] lock_lane,
    input  logic           restart,
    input  byte_t          order_byte,
    input  byte_t          pad_byte,
    output logic           out_valid,
    output logic [W-1:0]   out_data
);
    logic [SHW-1:0] shift;
    logic [W-1:0]   hold;
    logic [2*W-1:0] ext;
    logic [W-1:0]   cand [LANES];
    logic [W-1:0]   pad_word;

    assign ext = {hold, in_data};

    // one candidate per shift amount: held low bytes on top, current upper lanes below
    for (genvar s = 0; s < LANES; s++) begin : g_cand
        assign cand[s] = ext[s*BYTE_W +: W];
    end

    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            if (j == 0)
                pad_word[j*BYTE_W +: BYTE_W] = order_byte;
            else if (j <= int'(lock_lane))
                pad_word[j*BYTE_W +: BYTE_W] = pad_byte;
            else
                pad_word[j*BYTE_W +: BYTE_W] = in_data[j*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            shift     <= '0;
            hold      <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                hold     <= in_data;
                out_data <= lock ? pad_word : cand[shift];
            end
            if (lock)
                shift <= lock_lane;
            else if (restart)
                shift <= '0;
        end
    end
endmodule

// File: rtl/bo_order_align.sv
module bo_order_align
    import bo_pkg::*;
#(
    parameter int LANES = 4,
    localparam int W   = LANES * BYTE_W,
    localparam int SHW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pwr_dn,
    input  logic         mode_user,
    input  logic         ord_en,
    input  logic         sync_ok,
    input  logic [7:0]   order_byte,
    input  logic [7:0]   pad_byte,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         order_done
);
    logic           clr;
    logic           hit_any;
    logic [SHW-1:0] hit_lane;
    logic           lock;
    logic           restart;

    assign clr = rst | pwr_dn;

    bo_find #(.LANES(LANES)) u_find (
        .in_data    (in_data),
        .order_byte (order_byte),
        .hit_any    (hit_any),
        .hit_lane   (hit_lane)
    );

    bo_ctl u_ctl (
        .clk       (clk),
        .clr       (clr),
        .mode_user (mode_user),
        .ord_en    (ord_en),
        .sync_ok   (sync_ok),
        .in_valid  (in_valid),
        .hit_any   (hit_any),
        .lock      (lock),
        .restart   (restart),
        .done      (order_done)
    );

    bo_datapath #(.LANES(LANES)) u_dp (
        .clk        (clk),
        .clr        (clr),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .lock       (lock),
        .lock_lane  (hit_lane),
        .restart    (restart),
        .order_byte (order_byte),
        .pad_byte   (pad_byte),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );
endmodule

// File: rtl/bo_chk.sv
module bo_chk #(
    parameter int LANES = 4,
    localparam int W = LANES * 8
) (
    input logic         clk,
    input logic         rst,
    input logic         pwr_dn,
    input logic         mode_user,
    input logic         ord_en,
    input logic [7:0]   order_byte,
    input logic         in_valid,
    input logic [W-1:0] in_data,
    input logic         out_valid,
    input logic [W-1:0] out_data,
    input logic         order_done
);
    logic en_q_c;
    logic has_ord;

    always_ff @(posedge clk) begin
        if (rst) en_q_c <= 1'b0;
        else     en_q_c <= ord_en;
    end

    always_comb begin
        has_ord = 1'b0;
        for (int i = 0; i < LANES; i++)
            if (in_data[i*8 +: 8] == order_byte) has_ord = 1'b1;
    end

    // R1
    clear_state_chk: assert property (@(posedge clk)
        (rst || pwr_dn) |=> (!order_done && !out_valid));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst || pwr_dn)
        in_valid |=> out_valid);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst || pwr_dn)
        !in_valid |=> !out_valid);

    // R3
    no_lock_without_byte_chk: assert property (@(posedge clk) disable iff (rst || pwr_dn)
        (!order_done && !(in_valid && has_ord)) |=> !order_done);

    // R4
    lane0_on_lock_chk: assert property (@(posedge clk) disable iff (rst || pwr_dn)
        $rose(order_done) |-> (out_valid && out_data[7:0] == order_byte));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst || pwr_dn)
        (order_done && !(mode_user && ord_en && !en_q_c)) |=> order_done);
endmodule

bind bo_order_align bo_chk #(.LANES(LANES)) u_bo_chk (
    .clk        (clk),
    .rst        (rst),
    .pwr_dn     (pwr_dn),
    .mode_user  (mode_user),
    .ord_en     (ord_en),
    .order_byte (order_byte),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .order_done (order_done)
);

// File: tb/tb_bo_order_align.sv
`timescale 1ns/1ps
module tb_bo_order_align;
    localparam int LANES = 4;
    localparam int W = LANES * 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pwr_dn = 1'b0;
    logic         mode_user = 1'b0;
    logic         ord_en = 1'b0;
    logic         sync_ok = 1'b0;
    logic [7:0]   order_byte = 8'hBC;
    logic [7:0]   pad_byte = 8'h9C;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         out_valid;
    logic [W-1:0] out_data;
    logic         order_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bo_order_align #(.LANES(LANES)) dut (
        .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .mode_user(mode_user),
        .ord_en(ord_en), .sync_ok(sync_ok), .order_byte(order_byte),
        .pad_byte(pad_byte), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .order_done(order_done)
    );

    // {valid, sync, data[31:0], exp_valid, exp_data[31:0], exp_done}, automatic mode
    localparam logic [67:0] VEC [0:6] = '{
        {1'b1, 1'b0, 32'h11BC2233, 1'b1, 32'h11BC2233, 1'b0}, // R3 no sync, no search
        {1'b1, 1'b1, 32'h44556677, 1'b1, 32'h44556677, 1'b0}, // R2 passthrough
        {1'b1, 1'b1, 32'hA1BCA3A4, 1'b1, 32'hA19C9CBC, 1'b1}, // R4 lane 2 -> 2 pads
        {1'b1, 1'b1, 32'hB1B2B3B4, 1'b1, 32'hA3A4B1B2, 1'b1}, // R5 holdover
        {1'b1, 1'b1, 32'hC1C2BCC4, 1'b1, 32'hB3B4C1C2, 1'b1}, // R8 frozen shift
        {1'b0, 1'b1, 32'hDEADBEEF, 1'b0, 32'h00000000, 1'b1}, // R2 idle word
        {1'b1, 1'b1, 32'hD1D2D3D4, 1'b1, 32'hBCC4D1D2, 1'b1}  // R2 idle not held
    };

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [W-1:0] d);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset valid", W'(out_valid), '0);
        check("R1 reset done", W'(order_done), '0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic expect_word(input string tag, input logic [W-1:0] d, input logic dn);
        check({tag, " data"}, out_data, d);
        check({tag, " done"}, W'(order_done), W'(dn));
        check({tag, " valid"}, W'(out_valid), W'(1'b1));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 initial valid", W'(out_valid), '0);
        check("R1 initial done", W'(order_done), '0);
        @(negedge clk);
        rst = 1'b0;

        // vector table, automatic mode
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            in_valid = VEC[i][67];
            sync_ok  = VEC[i][66];
            in_data  = VEC[i][65:34];
            @(posedge clk);
            #1;
            check($sformatf("R2 vec%0d valid", i), W'(out_valid), W'(VEC[i][33]));
            if (VEC[i][33])
                check($sformatf("R4/R5 vec%0d data", i), out_data, VEC[i][32:1]);
            check($sformatf("R9 vec%0d done", i), W'(order_done), W'(VEC[i][0]));
        end

        // R6: ordering byte already in lane 0
        do_reset();
        step(1'b1, 32'h010203BC);
        expect_word("R6 lock lane0", 32'h010203BC, 1'b1);
        step(1'b1, 32'h05060708);
        expect_word("R6 no shift", 32'h05060708, 1'b1);

        // R7: two ordering bytes, lowest lane (1) wins
        do_reset();
        step(1'b1, 32'hBC11BC22);
        expect_word("R7 lowest lane", 32'hBC119CBC, 1'b1);
        step(1'b1, 32'h33445566);
        expect_word("R7 holdover", 32'h22334455, 1'b1);

        // R4/R5: top lane, three pads
        do_reset();
        step(1'b1, 32'hBC010203);
        expect_word("R4 top lane", 32'h9C9C9CBC, 1'b1);
        step(1'b1, 32'h04050607);
        expect_word("R5 three held", 32'h01020304, 1'b1);

        // R1: power-down clears done
        @(negedge clk);
        pwr_dn = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R1 pwr_dn done", W'(order_done), '0);
        check("R1 pwr_dn valid", W'(out_valid), '0);
        @(negedge clk);
        pwr_dn = 1'b0;

        // user mode
        do_reset();
        mode_user = 1'b1;
        sync_ok = 1'b1;
        step(1'b1, 32'h12BC3456);
        expect_word("R10 no edge no search", 32'h12BC3456, 1'b0);
        ord_en = 1'b1;
        step(1'b1, 32'h7777BC77);
        expect_word("R10 edge word unsearched", 32'h7777BC77, 1'b0);
        ord_en = 1'b0;
        step(1'b1, 32'h11111111);
        expect_word("R10 seek nomatch", 32'h11111111, 1'b0);
        ord_en = 1'b1;
        step(1'b1, 32'h22222222);
        expect_word("R10 edge during seek", 32'h22222222, 1'b0);
        step(1'b1, 32'h88BC8888);
        expect_word("R10 lock", 32'h889C9CBC, 1'b1);
        step(1'b1, 32'h99999999);
        expect_word("R10 holdover", 32'h88889999, 1'b1);
        step(1'b1, 32'hAABCAAAA);
        expect_word("R10 level held no restart", 32'h9999AABC, 1'b1);
        ord_en = 1'b0;
        step(1'b1, 32'h01020304);
        expect_word("R9 sticky", 32'hAAAA0102, 1'b1);
        ord_en = 1'b1;
        step(1'b1, 32'h05060708);
        expect_word("R11 restart clears done", 32'h03040506, 1'b0);
        step(1'b1, 32'h0A0B0C0D);
        expect_word("R11 zero shift", 32'h0A0B0C0D, 1'b0);
        step(1'b1, 32'h0E0F10BC);
        expect_word("R11 relock", 32'h0E0F10BC, 1'b1);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule